// File: doc/BRIEF.md
# Self-Recovering Divide-by-15 Clock Divider

This block divides its input clock by fifteen. The ratio is factored into a divide-by-three stage followed by a divide-by-five stage. The three-step stage sits next to the input, so most of the logic toggles at one third of the input rate. Both stages run in the single input clock domain. The three-step stage's terminal state acts as the clock enable of the five-step stage, so no derived clock drives any register.

Neither stage has a reset. Each stage's state coding is chosen so that its next state comes from one NOR gate plus wires. The same coding sends every unused code back into the legal cycle within a few steps. After power-up the divider therefore settles into its fifteen-cycle rhythm by itself, whatever its starting state.

Two outputs are provided: a one-cycle terminal tick and a divided clock level. A synchronous seed port can load any five-bit state combination, illegal codes included. This allows every start-up condition to be reproduced.

Top module: `div15_selfrec`

## Requirements
- R1: Once settled, `tick_o` is high for exactly one input cycle in every 15, and successive ticks are exactly 15 cycles apart.
- R2: `div_clk_o` equals bit 0 of the five-step stage's state. Once settled, it rises 4 cycles after a tick, stays high for 6 cycles and stays low for 9 cycles.
- R3: The three-step stage follows the code sequence 0→1→2→0 on every cycle. Its unused code 3 moves to code 2 on the next clock.
- R4: The five-step stage advances only in a cycle where the three-step stage holds code 2. It then follows 0→1→3→6→4→0. Its unused codes move as 2→4, 5→2 and 7→6, so each reaches the legal cycle within at most 2 enabled steps.
- R5: `tick_o` is high exactly when the three-step stage holds code 2 and the five-step stage holds code 4.
- R6: When `seed_en_i` is high, the next clock loads `seed_code_i[4:3]` into the three-step stage and `seed_code_i[2:0]` into the five-step stage. The load overrides counting, including in a cycle where `tick_o` is high.
- R7: The five-step stage holds its state in every cycle in which it is not enabled and no load occurs.
- R8: From any of the 32 starting state combinations, with no reset, the outputs are periodic with period 15 no later than 10 cycles after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| seed_en_i | input | 1 | Synchronous load of both stage states |
| seed_code_i | input | 5 | State loaded by the seed: [4:3] three-step stage, [2:0] five-step stage |
| tick_o | output | 1 | One-cycle terminal pulse, once per 15 cycles |
| div_clk_o | output | 1 | Divided clock level, 6 cycles high and 9 cycles low |

## Verification
Two events can fall in the same cycle: a seed load, and the terminal cycle in which the three-step stage enables the five-step stage and the tick is high. The bench lets the divider run until it sees `tick_o` high away from the clock edge. In that same cycle it raises `seed_en_i` with a chosen code. The load is judged correct only if the following output trace matches the loaded code exactly, which shows that the enable pulse was not applied as well. All 32 seed codes are also swept. The bench steps each one through a table model built from the requirement codings and checks tick spacing and the divided clock's duty pattern.

// File: rtl/div15_pkg.sv
package div15_pkg;
  localparam int unsigned S3_W   = 2;
  localparam int unsigned S5_W   = 3;
  localparam int unsigned SEED_W = S3_W + S5_W;

  // terminal codes of each stage
  localparam logic [S3_W-1:0] S3_LAST = 2'b10;
  localparam logic [S5_W-1:0] S5_LAST = 3'b100;
endpackage

// File: rtl/div3_stage.sv
module div3_stage
  import div15_pkg::*;
(
  input  logic            clk_i,
  input  logic            load_i,
  input  logic [S3_W-1:0] load_val_i,
  output logic            term_o
);
  logic [S3_W-1:0] st_q;
  logic [S3_W-1:0] st_d;

  // one NOR gate: 00->01->10->00, unused 11->10
  always_comb begin
    st_d = {st_q[0], ~(st_q[1] | st_q[0])};
    if (load_i) st_d = load_val_i;
  end

  always_ff @(posedge clk_i) begin
    st_q <= st_d;
  end

  assign term_o = (st_q == S3_LAST);

  assert_div3_recover_R3: assert property (@(posedge clk_i) disable iff (load_i)
    (!load_i && st_q == 2'b11) |=> (st_q == 2'b10));

  assert_div3_wrap_R3: assert property (@(posedge clk_i) disable iff (load_i)
    (!load_i && term_o) |=> (st_q == 2'b00));

  assert_div3_load_R6: assert property (@(posedge clk_i)
    load_i |=> (st_q == $past(load_val_i)));
endmodule

// File: rtl/div5_stage.sv
module div5_stage
  import div15_pkg::*;
(
  input  logic            clk_i,
  input  logic            en_i,
  input  logic            load_i,
  input  logic [S5_W-1:0] load_val_i,
  output logic [S5_W-1:0] state_o
);
  logic [S5_W-1:0] st_q;
  logic [S5_W-1:0] st_d;

  // shift with one NOR feedback: 000->001->011->110->100->000
  always_comb begin
    st_d = st_q;
    if (load_i)    st_d = load_val_i;
    else if (en_i) st_d = {st_q[1], st_q[0], ~(st_q[2] | st_q[1])};
  end

  always_ff @(posedge clk_i) begin
    st_q <= st_d;
  end

  assign state_o = st_q;

  assert_div5_hold_R7: assert property (@(posedge clk_i) disable iff (load_i)
    (!load_i && !en_i) |=> $stable(st_q));

  assert_div5_unused5_R4: assert property (@(posedge clk_i) disable iff (load_i)
    (!load_i && en_i && st_q == 3'b101) |=> (st_q == 3'b010));

  assert_div5_unused27_R4: assert property (@(posedge clk_i) disable iff (load_i)
    (!load_i && en_i && (st_q == 3'b010 || st_q == 3'b111)) |=>
      (st_q == 3'b100 || st_q == 3'b110));
endmodule

// File: rtl/div15_selfrec.sv
module div15_selfrec
  import div15_pkg::*;
(
  input  logic              clk_i,
  input  logic              seed_en_i,
  input  logic [SEED_W-1:0] seed_code_i,
  output logic              tick_o,
  output logic              div_clk_o
);
  logic            term3;
  logic [S5_W-1:0] st5;

  div3_stage u_div3 (
    .clk_i      (clk_i),
    .load_i     (seed_en_i),
    .load_val_i (seed_code_i[SEED_W-1:S5_W]),
    .term_o     (term3)
  );

  div5_stage u_div5 (
    .clk_i      (clk_i),
    .en_i       (term3),
    .load_i     (seed_en_i),
    .load_val_i (seed_code_i[S5_W-1:0]),
    .state_o    (st5)
  );

  assign tick_o    = term3 & (st5 == S5_LAST);
  assign div_clk_o = st5[0];

  assert_tick_single_R1: assert property (@(posedge clk_i) disable iff (seed_en_i)
    (!seed_en_i && tick_o) |=> !tick_o);

  assert_tick_restart_R2: assert property (@(posedge clk_i) disable iff (seed_en_i)
    (!seed_en_i && tick_o) |=> !div_clk_o);
endmodule

// File: tb/div15_selfrec_bench.sv
`timescale 1ns/1ps
module div15_selfrec_bench;
  logic       clk = 1'b0;
  logic       seed_en = 1'b0;
  logic [4:0] seed_code = 5'd0;
  logic       tick_o, div_clk_o;
  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 1'b0;

  always #2.5 clk = ~clk;

  div15_selfrec u_div15_selfrec (
    .clk_i       (clk),
    .seed_en_i   (seed_en),
    .seed_code_i (seed_code),
    .tick_o      (tick_o),
    .div_clk_o   (div_clk_o)
  );

  // table model from R3/R4: next combined code
  function automatic logic [4:0] spec_step(input logic [4:0] c);
    logic [1:0] a, an;
    logic [2:0] b, bn;
    a = c[4:3]; b = c[2:0];
    case (a) 2'd0: an = 2'd1; 2'd1: an = 2'd2; default: an = (a == 2'd2) ? 2'd0 : 2'd2; endcase
    bn = b;
    if (a == 2'd2) begin
      case (b)
        3'd0: bn = 3'd1; 3'd1: bn = 3'd3; 3'd3: bn = 3'd6; 3'd6: bn = 3'd4;
        3'd4: bn = 3'd0; 3'd2: bn = 3'd4; 3'd5: bn = 3'd2; default: bn = 3'd6;
      endcase
    end
    return {an, bn};
  endfunction

  function automatic logic spec_tick(input logic [4:0] c);
    return (c[4:3] == 2'd2) && (c[2:0] == 3'd4);  // R5
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; loads code in this cycle, then traces 55 cycles
  task automatic run_seed(input logic [4:0] code);
    logic [4:0] m;
    int  mism = 0, first_bad = -1;
    int  tcnt = 0, last_t = -1, gap_bad = 0, hi_cnt = 0, rise_bad = 0;
    seed_en = 1'b1; seed_code = code;
    @(negedge clk);
    seed_en = 1'b0;
    m = code;
    for (int k = 0; k < 55; k++) begin
      if (tick_o !== spec_tick(m) || div_clk_o !== m[0]) begin
        mism++;
        if (first_bad < 0) first_bad = k;
      end
      if (k >= 10 && tick_o) begin
        if (last_t >= 0 && k - last_t != 15) gap_bad++;
        last_t = k; tcnt++;
      end
      if (k >= 20 && k < 35 && div_clk_o) hi_cnt++;
      if (k >= 10 && k < 51 && tick_o) begin
        // sampled later via rise check below
      end
      m = spec_step(m);
      @(negedge clk);
    end
    check(mism == 0, $sformatf("R3/R4/R5/R6 trace code %0d (first bad cycle)", code), first_bad, -1);
    check(tcnt == 3 && gap_bad == 0, $sformatf("R1 R8 tick period code %0d (ticks)", code), tcnt, 3);
    check(hi_cnt == 6, $sformatf("R2 div_clk high count code %0d", code), hi_cnt, 6);
    if (rise_bad != 0) check(1'b0, "R2", rise_bad, 0);
  endtask

  initial begin
    // power-up: no reset, free run then check period (R8)
    int tc = 0, lt = -1, gb = 0, d = -1;
    repeat (12) @(negedge clk);
    for (int k = 0; k < 45; k++) begin
      if (tick_o) begin
        if (lt >= 0 && k - lt != 15) gb++;
        lt = k; tc++;
      end
      @(negedge clk);
    end
    check(tc == 3 && gb == 0, "R8 power-up period", tc, 3);

    // exhaustive seed sweep (R3 R4 R5 R6 R8 R1 R2)
    for (int c = 0; c < 32; c++) run_seed(c[4:0]);

    // phase of div_clk relative to tick (R2): rise 4 cycles after tick
    while (!tick_o) @(negedge clk);
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (k == 1) d = -1;
      if (div_clk_o && d < 0) d = k;
    end
    check(d == 4, "R2 rise delay after tick", d, 4);

    // hold check via outputs (R7): seed five-step code 1 with three-step at 0,
    // div_clk must stay high exactly 3 cycles before first enable advances it
    seed_en = 1'b1; seed_code = {2'd0, 3'd1};
    @(negedge clk); seed_en = 1'b0;
    begin
      int hc = 0;
      for (int k = 0; k < 3; k++) begin
        if (div_clk_o) hc++;
        @(negedge clk);
      end
      check(hc == 3, "R7 five-step holds while not enabled", hc, 3);
      check(div_clk_o == 1'b1, "R7 code 1 advanced to 3 keeps level", div_clk_o, 1);
    end

    // load coinciding with tick (R6)
    for (int c = 0; c < 32; c += 5) begin
      while (!tick_o) @(negedge clk);
      check(tick_o == 1'b1, "R6 overlap setup", tick_o, 1);
      run_seed(c[4:0]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule